// File: doc/BRIEF.md
# A/D Conversion Control Sequencer

This block is the digital front end of a successive-approximation A/D converter in a small 8-bit microcontroller. Software reaches it through a byte-wide register port. One register holds the power-down bit and the conversion-clock select. The other holds the analog pin enables, the START control, the end-of-conversion flag, the interrupt flag and the interrupt enable. The block derives a conversion step enable from the system clock through a selectable prescaler. It decides from the power bit and the pin enables whether the converter may run. It drives the trial code to the external DAC and uses the comparator decision to resolve one result bit per step.

A conversion is armed by raising START and launched only when START falls again. While START stays high the sequencer is held in reset. Completion clears the end-of-conversion flag, latches the 10-bit result, sets the sticky interrupt flag and, when enabled, emits a one-cycle interrupt request.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, address 0 reads 0x80 (bit 7 test bit = 1, bit 6 power-off = 0, bits 2..0 clock select = 0) and address 1 reads 0x40; bits 5..3 of address 0 always read 0; the test bit is writable.
- R2: With clock select code c (000→/2, 001→/8, 010→/32, 100→/1, 101→/4, 110→/16), the end-of-conversion bit (address 1 bit 6) reads 0 exactly 1 + 11·ratio clock edges after the edge that writes START (address 1 bit 7) back to 0.
- R3: With clock select 011 or 111 a launched conversion makes no progress: the end-of-conversion bit stays 1 and no interrupt flag is set.
- R4: The converter is on (adc_on = 1) only when the power-off bit is 0 and pin enables (address 1 bits 3..0) are nonzero; pwr_down follows the power-off bit; a START pulse while off starts nothing.
- R5: While START reads 1 the end-of-conversion bit reads 1 from the next edge on, and no conversion completes.
- R6: Writing START = 0 without a preceding START = 1 starts no conversion.
- R7: After launch, sample_on is high for the first step; then 10 steps resolve the result MSB first, a bit being kept when cmp_in = 1 for the trial code on dac_code; the result reads as bits 7..0 at address 2 and bits 9..8 in bits 1..0 at address 3.
- R8: On completion the end-of-conversion bit goes to 0, the interrupt flag (address 1 bit 5) goes to 1, and irq_req pulses high for one cycle only if the interrupt enable (address 1 bit 4) is 1.
- R9: Turning the converter off mid-conversion returns the sequencer to idle with the end-of-conversion bit left at 1, no interrupt flag and no irq_req.
- R10: Writing 1 to address 1 bit 5 clears the interrupt flag; writing 0 there leaves it set; a completion in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 2 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 2 | Read address |
| bus_rdata | output | 8 | Read data (combinational) |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at or above dac_code |
| dac_code | output | 10 | Trial code for the DAC |
| sample_on | output | 1 | High during the sample step |
| adc_on | output | 1 | Converter enabled |
| pwr_down | output | 1 | Analog power-down request |
| irq_req | output | 1 | One-cycle interrupt request |

## Verification
A register write lands on the edge that ends its strobe cycle. Sequencer state follows one edge later, and the end-of-conversion bit, the result and irq_req change together on the edge of the last step, 1 + 11·ratio edges after START is cleared. The bench keeps a cycle-level model that applies the same one-edge latency, and it compares the control byte, irq_req, adc_on and pwr_down at every falling edge. The explicit timing check counts falling edges from the write that clears START. Result and clock-register reads are taken a quarter period after a falling edge, and the read address is restored before the next one.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int unsigned MAX_DIV   = 32;
  localparam int unsigned DIV_CNT_W = $clog2(MAX_DIV);

  localparam logic [1:0] REG_CLK    = 2'd0;
  localparam logic [1:0] REG_CTL    = 2'd1;
  localparam logic [1:0] REG_RES_LO = 2'd2;
  localparam logic [1:0] REG_RES_HI = 2'd3;

  localparam int unsigned CTL_START_BIT = 7;
  localparam int unsigned CTL_EOC_BIT   = 6;
  localparam int unsigned CTL_FLAG_BIT  = 5;
  localparam int unsigned CTL_IE_BIT    = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_HOLD,
    SEQ_SAMPLE,
    SEQ_CONV
  } seq_state_e;

  typedef struct packed {
    logic       test;
    logic       pwr_off;
    logic [2:0] clk_sel;
  } clk_reg_t;

  typedef struct packed {
    logic       start;
    logic       irq_en;
    logic [3:0] pin_cfg;
  } ctl_reg_t;

  // Divide ratio for a clock-select code; 0 marks a reserved code.
  function automatic logic [DIV_CNT_W:0] div_ratio(input logic [2:0] sel);
    case (sel)
      3'b000:  return (DIV_CNT_W+1)'(2);
      3'b001:  return (DIV_CNT_W+1)'(8);
      3'b010:  return (DIV_CNT_W+1)'(32);
      3'b100:  return (DIV_CNT_W+1)'(1);
      3'b101:  return (DIV_CNT_W+1)'(4);
      3'b110:  return (DIV_CNT_W+1)'(16);
      default: return '0;
    endcase
  endfunction

  function automatic logic sel_reserved(input logic [2:0] sel);
    return sel[1:0] == 2'b11;
  endfunction

endpackage

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);

  logic [DIV_CNT_W:0]   ratio;
  logic [DIV_CNT_W:0]   last;
  logic [DIV_CNT_W-1:0] cnt;
  logic                 bad_sel;

  assign ratio   = div_ratio(sel);
  assign last    = ratio - 1'b1;
  assign bad_sel = sel_reserved(sel);
  assign tick    = run && !bad_sel && ({1'b0, cnt} == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick || bad_sel) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start_lvl,
  input  logic             tick,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             done,
  output logic             sample_on,
  output logic             converting,
  output logic             busy
);

  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

  seq_state_e       state;
  logic [IDX_W-1:0] bit_idx;
  logic [RES_W-1:0] trial;
  logic [RES_W-1:0] decided;
  logic [RES_W-1:0] next_trial;
  logic             last_step;

  // Keep or drop the bit under test according to the comparator.
  function automatic logic [RES_W-1:0] sar_resolve(input logic [RES_W-1:0] code,
                                                   input logic [IDX_W-1:0] idx,
                                                   input logic keep);
    logic [RES_W-1:0] mask;
    mask = RES_W'(1) << idx;
    return keep ? code : (code & ~mask);
  endfunction

  // Raise the next lower bit as the new trial; nothing below bit 0.
  function automatic logic [RES_W-1:0] sar_probe(input logic [RES_W-1:0] code,
                                                 input logic [IDX_W-1:0] idx);
    logic [RES_W-1:0] mask;
    mask = (RES_W'(1) << idx) >> 1;
    return code | mask;
  endfunction

  assign decided    = sar_resolve(trial, bit_idx, cmp_in);
  assign next_trial = sar_probe(decided, bit_idx);
  assign dac_code   = trial;
  assign sample_on  = (state == SEQ_SAMPLE);
  assign converting = (state == SEQ_CONV);
  assign busy       = sample_on || converting;
  assign last_step  = converting && tick && (bit_idx == '0);
  assign done       = enable && !start_lvl && last_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      trial   <= '0;
      bit_idx <= '0;
      result  <= '0;
    end else if (!enable) begin
      state <= SEQ_IDLE;
      trial <= '0;
    end else if (start_lvl) begin
      state <= SEQ_HOLD;
      trial <= '0;
    end else begin
      case (state)
        SEQ_HOLD: state <= SEQ_SAMPLE;
        SEQ_SAMPLE: begin
          if (tick) begin
            state   <= SEQ_CONV;
            bit_idx <= TOP_IDX;
            trial   <= RES_W'(1) << TOP_IDX;
          end
        end
        SEQ_CONV: begin
          if (tick) begin
            if (bit_idx == '0) begin
              result <= decided;
              trial  <= '0;
              state  <= SEQ_IDLE;
            end else begin
              trial   <= next_trial;
              bit_idx <= bit_idx - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rd_data,
  input  logic [RES_W-1:0] result,
  input  logic             done,
  output clk_reg_t         clk_q,
  output ctl_reg_t         ctl_q,
  output logic             eocb,
  output logic             irq_flag,
  output logic             irq_req
);

  logic        wr_clk;
  logic        wr_ctl;
  logic        flag_clr;
  logic [15:0] res_ext;

  assign wr_clk   = wr_en && (wr_addr == REG_CLK);
  assign wr_ctl   = wr_en && (wr_addr == REG_CTL);
  assign flag_clr = wr_ctl && wr_data[CTL_FLAG_BIT];
  assign res_ext  = 16'(result);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q    <= '{test: 1'b1, pwr_off: 1'b0, clk_sel: 3'b000};
      ctl_q    <= '0;
      eocb     <= 1'b1;
      irq_flag <= 1'b0;
      irq_req  <= 1'b0;
    end else begin
      irq_req <= done && ctl_q.irq_en;

      if (ctl_q.start)  eocb <= 1'b1;
      else if (done)    eocb <= 1'b0;

      if (done)          irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;

      if (wr_clk) begin
        clk_q <= '{test: wr_data[7], pwr_off: wr_data[6], clk_sel: wr_data[2:0]};
      end
      if (wr_ctl) begin
        ctl_q <= '{start:   wr_data[CTL_START_BIT],
                   irq_en:  wr_data[CTL_IE_BIT],
                   pin_cfg: wr_data[3:0]};
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_CLK: rd_data = {clk_q.test, clk_q.pwr_off, 3'b000, clk_q.clk_sel};
      REG_CTL: begin
        rd_data[CTL_START_BIT] = ctl_q.start;
        rd_data[CTL_EOC_BIT]   = eocb;
        rd_data[CTL_FLAG_BIT]  = irq_flag;
        rd_data[CTL_IE_BIT]    = ctl_q.irq_en;
        rd_data[3:0]           = ctl_q.pin_cfg;
      end
      REG_RES_LO: rd_data = res_ext[7:0];
      default:    rd_data = res_ext[15:8];
    endcase
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_waddr,
  input  logic [7:0]       bus_wdata,
  input  logic [1:0]       bus_raddr,
  output logic [7:0]       bus_rdata,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             sample_on,
  output logic             adc_on,
  output logic             pwr_down,
  output logic             irq_req
);

  clk_reg_t         clk_q;
  ctl_reg_t         ctl_q;
  logic             eocb;
  logic             irq_flag;
  logic [RES_W-1:0] result;
  logic             done;
  logic             tick;
  logic             busy;
  logic             converting;
  logic             start_q;
  logic             sel_bad;

  assign start_q  = ctl_q.start;
  assign adc_on   = !clk_q.pwr_off && (|ctl_q.pin_cfg);
  assign pwr_down = clk_q.pwr_off;
  assign sel_bad  = sel_reserved(clk_q.clk_sel);

  adc_ctrl_regs #(.RES_W(RES_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .wr_addr  (bus_waddr),
    .wr_data  (bus_wdata),
    .rd_addr  (bus_raddr),
    .rd_data  (bus_rdata),
    .result   (result),
    .done     (done),
    .clk_q    (clk_q),
    .ctl_q    (ctl_q),
    .eocb     (eocb),
    .irq_flag (irq_flag),
    .irq_req  (irq_req)
  );

  adc_clk_prescaler u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .sel   (clk_q.clk_sel),
    .tick  (tick)
  );

  adc_sar_sequencer #(.RES_W(RES_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (adc_on),
    .start_lvl  (start_q),
    .tick       (tick),
    .cmp_in     (cmp_in),
    .dac_code   (dac_code),
    .result     (result),
    .done       (done),
    .sample_on  (sample_on),
    .converting (converting),
    .busy       (busy)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adc_on,
  input logic             start_q,
  input logic             eocb,
  input logic             irq_flag,
  input logic             irq_req,
  input logic             done,
  input logic             tick,
  input logic             sel_bad,
  input logic             busy,
  input logic [RES_W-1:0] result
);

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  a_r8_done_clears_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !eocb);

  a_r8_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq_flag);

  a_r9_off_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_on |-> !done);

  a_r4_off_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_on |=> !busy);

  a_r3_reserved_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sel_bad |-> !tick);

  a_r5_hold_forces_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> eocb);

  a_r7_result_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result));

endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .adc_on   (adc_on),
  .start_q  (start_q),
  .eocb     (eocb),
  .irq_flag (irq_flag),
  .irq_req  (irq_req),
  .done     (done),
  .tick     (tick),
  .sel_bad  (sel_bad),
  .busy     (busy),
  .result   (result)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_waddr = 2'd0;
  logic [1:0] bus_raddr = 2'd1;
  logic [7:0] bus_wdata = 8'h00;
  logic [9:0] vin = 10'd0;
  wire  [7:0] bus_rdata;
  wire        cmp_in;
  wire  [9:0] dac_code;
  wire        sample_on, adc_on, pwr_down, irq_req;

  int total = 0;
  int bad = 0;
  int irq_seen = 0;
  bit finished = 0;

  // reference model state
  int m_state, m_cnt, m_adonb, m_cs, m_start, m_ie, m_pcr;
  int m_eocb, m_flag, m_irq, m_result, m_r;
  bit m_en, m_fin;

  assign cmp_in = (dac_code <= vin);

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .cmp_in(cmp_in), .dac_code(dac_code), .sample_on(sample_on),
    .adc_on(adc_on), .pwr_down(pwr_down), .irq_req(irq_req)
  );

  function automatic int ref_ratio(int code);
    if ((code & 3) == 3) return 0;
    return ((code & 4) != 0) ? (1 << (2 * (code & 3))) : (2 << (2 * (code & 3)));
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_adonb = 0; m_cs = 0; m_start = 0; m_ie = 0;
      m_pcr = 0; m_eocb = 1; m_flag = 0; m_irq = 0; m_result = 0;
    end else begin
      m_en  = (m_adonb == 0) && (m_pcr != 0);
      m_r   = ref_ratio(m_cs);
      m_fin = 0;
      if (m_start != 0) m_eocb = 1;
      if (!m_en) m_state = 0;
      else if (m_start != 0) m_state = 1;
      else if (m_state == 1) begin m_state = 2; m_cnt = 0; end
      else if (m_state == 2 && m_r != 0) begin
        m_cnt++;
        if (m_cnt == 11 * m_r) begin m_fin = 1; m_state = 0; end
      end
      m_irq = (m_fin && m_ie != 0) ? 1 : 0;
      if (m_fin) begin m_eocb = 0; m_result = vin; end
      if (m_fin) m_flag = 1;
      else if (bus_wr && bus_waddr == 2'd1 && bus_wdata[5]) m_flag = 0;
      if (bus_wr && bus_waddr == 2'd0) begin
        m_adonb = bus_wdata[6]; m_cs = bus_wdata[2:0];
      end
      if (bus_wr && bus_waddr == 2'd1) begin
        m_start = bus_wdata[7]; m_ie = bus_wdata[4]; m_pcr = bus_wdata[3:0];
      end
    end
  end

  // every-cycle comparison against the model (R5 R8 R10 R4)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (irq_req) irq_seen++;
      check("R8 ctl byte", bus_rdata,
            {m_start[0], m_eocb[0], m_flag[0], m_ie[0], m_pcr[3:0]});
      check("R8 irq_req", irq_req, m_irq);
      check("R4 adc_on", adc_on, (m_adonb == 0 && m_pcr != 0) ? 1 : 0);
      check("R4 pwr_down", pwr_down, m_adonb);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    #(CLK_PERIOD/4);
    bus_raddr = a;
    #1;
    v = bus_rdata;
    bus_raddr = 2'd1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_conv(input int cs, input int v, input int ie);
    int n, lo, hi, irq0, ctl;
    vin = v[9:0];
    wr(2'd0, 8'(cs));
    wr(2'd1, 8'h81 | 8'(ie << 4));
    irq0 = irq_seen;
    wr(2'd1, 8'h01 | 8'(ie << 4));
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) check("R7 sample step", sample_on, 1);
    end while (bus_rdata[6] && n < 2000);
    check("R2 conversion length", n, 1 + 11 * ref_ratio(cs));
    rd(2'd2, lo);
    rd(2'd3, hi);
    check("R7 result", (hi << 8) | lo, v);
    idle(2);
    check("R8 irq count", irq_seen - irq0, ie);
    rd(2'd1, ctl);
    check("R8 flag set", (ctl >> 5) & 1, 1);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); check("R1 clock reg reset", v, 8'h80);
    rd(2'd1, v); check("R1 ctl reg reset", v, 8'h40);
    rd(2'd2, v); check("R1 result lo reset", v, 0);
    rd(2'd3, v); check("R1 result hi reset", v, 0);
    wr(2'd0, 8'h38);
    rd(2'd0, v); check("R1 unimplemented bits", v, 8'h00);

    wr(2'd1, 8'h11);
    check("R4 on", adc_on, 1);
    wr(2'd0, 8'h40);
    check("R4 power off", adc_on, 0);
    check("R4 pwr_down", pwr_down, 1);
    wr(2'd0, 8'h00);

    run_conv(0, 10'h2AA, 1);
    run_conv(1, 10'h155, 1);
    run_conv(2, 1023, 1);
    run_conv(4, 0, 1);
    run_conv(5, 512, 0);
    run_conv(6, 1, 1);

    // R10 write-one-to-clear
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R10 write 0 keeps flag", (v >> 5) & 1, 1);
    wr(2'd1, 8'h21);
    rd(2'd1, v); check("R10 write 1 clears flag", (v >> 5) & 1, 0);

    // R6 START low without a high phase
    wr(2'd1, 8'h01);
    wr(2'd1, 8'h11);
    idle(200);
    rd(2'd1, v);
    check("R6 no launch eoc", (v >> 6) & 1, 0);
    check("R6 no launch flag", (v >> 5) & 1, 0);

    // R5 START held high
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h91);
    idle(60);
    rd(2'd1, v);
    check("R5 held eoc", (v >> 6) & 1, 1);
    check("R5 held no flag", (v >> 5) & 1, 0);
    wr(2'd1, 8'h11);
    idle(20);
    rd(2'd1, v);
    check("R5 release converts", (v >> 6) & 1, 0);

    // R3 reserved clock codes
    wr(2'd1, 8'h31);
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h91);
    wr(2'd1, 8'h11);
    idle(500);
    rd(2'd1, v);
    check("R3 code 011 eoc", (v >> 6) & 1, 1);
    check("R3 code 011 flag", (v >> 5) & 1, 0);
    wr(2'd0, 8'h07);
    idle(300);
    rd(2'd1, v);
    check("R3 code 111 eoc", (v >> 6) & 1, 1);
    check("R3 code 111 flag", (v >> 5) & 1, 0);
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h00);

    // R9 abort by power-off
    wr(2'd1, 8'h11);
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h91);
    v = irq_seen;
    wr(2'd1, 8'h11);
    idle(100);
    wr(2'd0, 8'h42);
    idle(500);
    check("R9 abort irq", irq_seen - v, 0);
    rd(2'd1, v);
    check("R9 abort eoc", (v >> 6) & 1, 1);
    check("R9 abort flag", (v >> 5) & 1, 0);
    wr(2'd0, 8'h02);
    idle(500);
    rd(2'd1, v);
    check("R9 stays idle", (v >> 6) & 1, 1);

    // R4 start pulse while pins disabled
    run_conv(4, 300, 1);
    wr(2'd1, 8'h31);
    vin = 10'd700;
    wr(2'd1, 8'h10);
    wr(2'd1, 8'h90);
    wr(2'd1, 8'h10);
    wr(2'd1, 8'h11);
    idle(100);
    rd(2'd1, v);
    check("R4 off start no flag", (v >> 5) & 1, 0);
    rd(2'd2, v);
    check("R4 off start result kept", v, 300 & 8'hFF);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule